// File: doc/BRIEF.md
# Two-Channel Serial ADC Sequencer with Pipelined Channel Tagging

This block is the serial master for a two-input successive-approximation converter with a three-wire serial port plus chip select. A host asks for conversions one at a time over a ready/valid port, giving the input it wants for each. For each request, the block runs one 16-clock frame. In that frame it shifts the requested input address to the converter and captures the 12-bit sample the converter sends back.

The converter works one frame behind. The address written in frame N picks the input converted and returned in frame N+1. The converter keeps that address while chip select is high between frames. Only a power-up, mirrored here by the synchronous reset, returns it to the first input. The block therefore holds a pending-address register and tags every result with the input that actually produced it. The data of a frame belongs to the address sent in the frame before, or to the first input if no address has been sent since reset.

The serial clock is the system clock divided by a parameter. It idles high. The address bit changes on its falling edge, and the returned data is sampled on its rising edge. By default, chip select goes high for a programmable number of system clocks between frames. A parameter can instead keep it low across frames that follow each other directly.

Top module: `adc_chan_sequencer`

## Requirements
- R1: While in reset and right after reset, `csN` and `sclk` are high, `resultValid` is low and `reqReady` is low.
- R2: A frame holds `csN` low for exactly 16 rising edges of `sclk`. Inside a frame, consecutive rising edges of `sclk` are 2*DIV system clocks apart.
- R3: On `mosi`, the requested input is sent in serial-clock period 4 of the frame, counting the first period as 0. The value 0 selects the first input and 1 selects the second. `mosi` is 0 in every other period.
- R4: `resultData` holds the `miso` values sampled on the rising edges of periods 4 to 15, with the first of them as bit 11. The `miso` values in periods 0 to 3 do not affect it.
- R5: `resultChan` equals the input address sent in the previous frame. For the first frame after reset it is 0, the first input.
- R6: The pending address is kept across any time `csN` spends high, so the tag does not depend on how long the pause between frames is.
- R7: In toggling mode, `csN` stays high for at least IDLE_CYCLES system clocks between frames.
- R8: `resultValid` is high for exactly one clock per frame. The number of results equals the number of accepted requests.
- R9: Exactly one request is accepted per frame. In toggling mode, `reqReady` is never high while `csN` is low.
- R10: A synchronous reset given after the second input was addressed returns the pending address to the first input. The next result is then tagged 0.
- R11: `miso` values while `csN` is high do not affect any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Host offers a conversion request |
| reqChan | input | 1 | Requested input: 0 first, 1 second |
| reqReady | output | 1 | Block accepts the request this cycle |
| csN | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Address line to the converter |
| miso | input | 1 | Sample line from the converter, floating while csN is high |
| resultValid | output | 1 | One-cycle strobe for a new result |
| resultData | output | DATA_BITS | Captured sample, MSB first on the wire |
| resultChan | output | 1 | Input the sample belongs to |

## Verification
The request sequence alternates between the two inputs, repeats the same input several times, and puts long idle gaps between some requests. A tag that follows the current request instead of the previous one fails on the alternating runs. A pending address that is cleared while chip select is high fails after the long gaps. A bench model of the converter returns a sample that encodes both its own pending input and a running frame count, so a wrong tag, a lost frame and a shifted bit window each produce a distinct mismatch. The converter model drives ones in the four leading periods and toggles `miso` while chip select is high, so that sampling outside the data window shows up. A reset given after the second input was addressed checks the return to the first-input default.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // strobes from the sequencing control to the datapath
  typedef struct packed {
    logic loadAddr;   // request accepted, latch its address
    logic driveBit;   // serial clock falls, present next mosi bit
    logic sampleBit;  // serial clock rises, sample miso
    logic frameDone;  // last period ended, publish the result
  } seqStrobe_t;

  typedef enum logic [1:0] {ST_GAP, ST_LEAD, ST_SHIFT} seqState_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DIV         = 2,
  parameter int IDLE_CYCLES = 3,
  parameter int FRAME_BITS  = 16,
  parameter bit CS_TOGGLE   = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reqValid,
  output logic                          reqReady,
  output logic                          csN,
  output logic                          sclk,
  output seqStrobe_t                    strobe,
  output logic [$clog2(FRAME_BITS)-1:0] bitIdx,
  output logic [$clog2(FRAME_BITS)-1:0] driveIdx
);
  localparam int HALF_W = $clog2(DIV + 1);
  localparam int BIT_W  = $clog2(FRAME_BITS);
  localparam int GAP_W  = $clog2(IDLE_CYCLES + 1);
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [HALF_W-1:0] HALF_END = HALF_W'(DIV - 1);

  seqState_t         state;
  logic [HALF_W-1:0] halfCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic              phaseHigh;
  logic              csNQ, sclkQ;
  logic              halfEnd, lastBit, gapDone, accept;

  assign halfEnd = (halfCnt == HALF_END);
  assign lastBit = (bitCnt == LAST_BIT);
  assign gapDone = (gapCnt == GAP_W'(IDLE_CYCLES));

  always_comb begin
    reqReady = (state == ST_GAP) && gapDone;
    if (!CS_TOGGLE && state == ST_SHIFT && halfEnd && phaseHigh && lastBit)
      reqReady = 1'b1;
  end
  assign accept = reqValid && reqReady;

  always_comb begin
    strobe.loadAddr  = accept;
    strobe.sampleBit = (state == ST_SHIFT) && halfEnd && !phaseHigh;
    strobe.frameDone = (state == ST_SHIFT) && halfEnd && phaseHigh && lastBit;
    strobe.driveBit  = ((state == ST_LEAD) && halfEnd) ||
                       ((state == ST_SHIFT) && halfEnd && phaseHigh && (!lastBit || accept));
    driveIdx = (state == ST_LEAD || lastBit) ? '0 : bitCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_GAP;
      halfCnt   <= '0;
      bitCnt    <= '0;
      gapCnt    <= '0;
      phaseHigh <= 1'b1;
      csNQ      <= 1'b1;
      sclkQ     <= 1'b1;
    end else begin
      case (state)
        ST_GAP: begin
          if (!gapDone) gapCnt <= gapCnt + 1'b1;
          if (accept) begin
            state   <= ST_LEAD;
            csNQ    <= 1'b0;
            halfCnt <= '0;
          end
        end
        ST_LEAD: begin
          if (halfEnd) begin
            state     <= ST_SHIFT;
            sclkQ     <= 1'b0;
            phaseHigh <= 1'b0;
            bitCnt    <= '0;
            halfCnt   <= '0;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (!halfEnd) begin
            halfCnt <= halfCnt + 1'b1;
          end else begin
            halfCnt <= '0;
            if (!phaseHigh) begin
              sclkQ     <= 1'b1;
              phaseHigh <= 1'b1;
            end else if (!lastBit) begin
              bitCnt    <= bitCnt + 1'b1;
              sclkQ     <= 1'b0;
              phaseHigh <= 1'b0;
            end else if (accept) begin
              bitCnt    <= '0;
              sclkQ     <= 1'b0;
              phaseHigh <= 1'b0;
            end else begin
              state  <= ST_GAP;
              csNQ   <= 1'b1;
              gapCnt <= '0;
            end
          end
        end
        default: state <= ST_GAP;
      endcase
    end
  end

  assign csN    = csNQ;
  assign sclk   = sclkQ;
  assign bitIdx = bitCnt;

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    csNQ |-> sclkQ) else $error("sclk low outside a frame"); // R1
  AST_FALL_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    $fell(sclkQ) |-> !csNQ) else $error("sclk fell with csN high"); // R2
  AST_READY_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
    (CS_TOGGLE && reqReady) |-> csNQ) else $error("request taken inside a frame"); // R9
endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int DATA_BITS  = 12,
  parameter int ADDR_POS   = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  seqStrobe_t                    strobe,
  input  logic [$clog2(FRAME_BITS)-1:0] bitIdx,
  input  logic [$clog2(FRAME_BITS)-1:0] driveIdx,
  input  logic                          reqChan,
  input  logic                          miso,
  output logic                          mosi,
  output logic                          resultValid,
  output logic [DATA_BITS-1:0]          resultData,
  output logic                          resultChan
);
  localparam int BIT_W     = $clog2(FRAME_BITS);
  localparam int LEAD_BITS = FRAME_BITS - DATA_BITS;

  logic                 curAddr;      // address sent in the running frame
  logic                 pendingAddr;  // address the converter is using now
  logic [DATA_BITS-1:0] shiftReg;
  logic                 addrNow;

  assign addrNow = strobe.loadAddr ? reqChan : curAddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      curAddr     <= 1'b0;
      pendingAddr <= 1'b0;
      shiftReg    <= '0;
      mosi        <= 1'b0;
      resultValid <= 1'b0;
      resultData  <= '0;
      resultChan  <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      if (strobe.loadAddr) curAddr <= reqChan;
      if (strobe.driveBit)
        mosi <= (driveIdx == BIT_W'(ADDR_POS)) ? addrNow : 1'b0;
      else if (strobe.frameDone)
        mosi <= 1'b0;
      if (strobe.sampleBit && bitIdx >= BIT_W'(LEAD_BITS))
        shiftReg <= {shiftReg[DATA_BITS-2:0], miso};
      if (strobe.frameDone) begin
        resultValid <= 1'b1;
        resultData  <= shiftReg;
        resultChan  <= pendingAddr;
        pendingAddr <= curAddr;
      end
    end
  end

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    resultValid |=> !resultValid) else $error("result strobe wider than one clock"); // R8
  AST_TAG_FROM_PENDING: assert property (@(posedge clk) disable iff (rst)
    $rose(resultValid) |-> resultChan == $past(pendingAddr)) else $error("tag not the pending address"); // R5
  AST_PENDING_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    $rose(resultValid) |-> pendingAddr == $past(curAddr)) else $error("pending address not advanced"); // R6
endmodule

// File: rtl/adc_chan_sequencer.sv
module adc_chan_sequencer
  import adc_seq_pkg::*;
#(
  parameter int DIV         = 2,
  parameter int IDLE_CYCLES = 3,
  parameter int FRAME_BITS  = 16,
  parameter int DATA_BITS   = 12,
  parameter int ADDR_POS    = 4,
  parameter bit CS_TOGGLE   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reqValid,
  input  logic                 reqChan,
  output logic                 reqReady,
  output logic                 csN,
  output logic                 sclk,
  output logic                 mosi,
  input  logic                 miso,
  output logic                 resultValid,
  output logic [DATA_BITS-1:0] resultData,
  output logic                 resultChan
);
  localparam int BIT_W = $clog2(FRAME_BITS);

  seqStrobe_t       strobe;
  logic [BIT_W-1:0] bitIdx, driveIdx;

  adc_seq_ctrl #(
    .DIV(DIV), .IDLE_CYCLES(IDLE_CYCLES), .FRAME_BITS(FRAME_BITS), .CS_TOGGLE(CS_TOGGLE)
  ) i_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .csN(csN), .sclk(sclk), .strobe(strobe), .bitIdx(bitIdx), .driveIdx(driveIdx)
  );

  adc_seq_datapath #(
    .FRAME_BITS(FRAME_BITS), .DATA_BITS(DATA_BITS), .ADDR_POS(ADDR_POS)
  ) i_datapath (
    .clk(clk), .rst(rst), .strobe(strobe), .bitIdx(bitIdx), .driveIdx(driveIdx),
    .reqChan(reqChan), .miso(miso), .mosi(mosi), .resultValid(resultValid),
    .resultData(resultData), .resultChan(resultChan)
  );
endmodule

// File: tb/test_adc_chan_sequencer.sv
`timescale 1ns/1ps
module test_adc_chan_sequencer;
  localparam int DIV = 2, IDLE = 3, FB = 16, DB = 12, APOS = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic reqValid = 1'b0, reqChan = 1'b0;
  logic reqReady, csN, sclk, mosi, miso, resultValid, resultChan;
  logic [DB-1:0] resultData;

  always #2 clk = ~clk;

  adc_chan_sequencer #(.DIV(DIV), .IDLE_CYCLES(IDLE)) i_adc_chan_sequencer (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqChan(reqChan), .reqReady(reqReady),
    .csN(csN), .sclk(sclk), .mosi(mosi), .miso(miso), .resultValid(resultValid),
    .resultData(resultData), .resultChan(resultChan)
  );

  int vecs = 0, errs = 0;
  task automatic chk(input bit ok, input string msg);
    vecs++;
    if (!ok) begin errs++; $display("FAIL %s", msg); end
  endtask

  // converter model: one-frame address pipeline, floating line outside frames
  logic slvPend = 1'b0, slvNew = 1'b0, misoDrv = 1'b0, noiseBit = 1'b0;
  logic [FB-1:0] slvWord = '0;
  int slvIdx = 0, slvFrames = 0, strayMosi = 0;
  always @(posedge clk) noiseBit <= ~noiseBit;
  assign miso = csN ? noiseBit : misoDrv;

  always @(negedge sclk) if (!csN) begin
    if (slvIdx == 0) slvWord = {4'b1111, slvPend, 11'(slvFrames)};
    misoDrv = slvWord[FB-1-slvIdx];
  end
  always @(posedge sclk or posedge rst) begin
    if (rst) begin
      slvPend = 1'b0; slvIdx = 0;
    end else if (!csN) begin
      if (slvIdx == APOS) slvNew = mosi;
      else if (mosi) strayMosi++;
      slvIdx++;
      if (slvIdx == FB) begin
        chk(strayMosi == 0, $sformatf("R3 mosi high outside address period: got %0d exp 0", strayMosi));
        strayMosi = 0; slvPend = slvNew; slvFrames++; slvIdx = 0;
      end
    end
  end

  // scoreboard
  logic [DB-1:0] expD[$];
  logic          expC[$];
  logic prevReq = 1'b0, prevValid = 1'b0;
  int reqCount = 0, results = 0, readyInFrame = 0;

  task automatic sendReq(input logic c);
    @(negedge clk); reqValid = 1'b1; reqChan = c;
    while (!reqReady) @(negedge clk);
    @(posedge clk); #1;
    expD.push_back({prevReq, 11'(reqCount)});
    expC.push_back(prevReq);
    prevReq = c; reqCount++;
    reqValid = 1'b0;
  endtask

  always @(negedge clk) if (!rst) begin
    if (resultValid) begin
      results++;
      if (expD.size() == 0) chk(1'b0, "R8 result with no request: got 1 exp 0");
      else begin
        logic [DB-1:0] d; logic c;
        d = expD.pop_front(); c = expC.pop_front();
        chk(resultData == d, $sformatf("R4 data: got %h exp %h", resultData, d));
        chk(resultChan == c, $sformatf("R5 tag: got %0d exp %0d", resultChan, c));
      end
      if (prevValid) chk(1'b0, "R8 strobe width: got 2 exp 1");
    end
    prevValid = resultValid;
    if (!csN && reqReady) readyInFrame++;
  end

  // frame timing monitor
  logic sclkSeen = 1'b1, csSeen = 1'b1;
  int risesInFrame = 0, sinceRise = 0, badPeriod = 0, csHigh = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!csN) begin
        if (sclk && !sclkSeen) begin
          if (risesInFrame > 0 && sinceRise != 2*DIV) badPeriod++;
          risesInFrame++; sinceRise = 0;
        end
        sinceRise++;
      end
      if (csN && !csSeen) begin
        chk(risesInFrame == FB && badPeriod == 0,
            $sformatf("R2 frame: got %0d rises/%0d bad periods exp %0d/0", risesInFrame, badPeriod, FB));
        risesInFrame = 0; badPeriod = 0;
      end
      if (!csN && csSeen)
        chk(csHigh >= IDLE, $sformatf("R7 csN high time: got %0d exp >= %0d", csHigh, IDLE));
      csHigh = csN ? csHigh + 1 : 0;
    end
    sclkSeen = sclk; csSeen = csN;
  end

  task automatic drain();
    for (int i = 0; i < 2000 && expD.size() > 0; i++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(csN && sclk && !resultValid && !reqReady,
        $sformatf("R1 in reset: got cs=%b sclk=%b v=%b rdy=%b exp 1 1 0 0", csN, sclk, resultValid, reqReady));
    rst = 1'b0; prevReq = 1'b0;
    @(negedge clk);
    chk(csN && sclk && !resultValid && !reqReady,
        $sformatf("R1 after reset: got cs=%b sclk=%b v=%b rdy=%b exp 1 1 0 0", csN, sclk, resultValid, reqReady));
  endtask

  initial begin
    int framesBefore;
    doReset();
    // R5: first result after reset carries the first input
    sendReq(1'b1); sendReq(1'b1); sendReq(1'b0); sendReq(1'b1);   // alternating and repeated
    sendReq(1'b0); sendReq(1'b0);
    drain();
    repeat (300) @(negedge clk);                                   // R6 long pause
    sendReq(1'b1);
    drain();
    repeat (150) @(negedge clk);                                   // R6 pause with second input pending
    sendReq(1'b0); sendReq(1'b1); sendReq(1'b1);
    drain();
    // R10: reset with second input pending returns the tag to 0
    framesBefore = slvFrames;
    doReset();
    sendReq(1'b1); sendReq(1'b0); sendReq(1'b1);
    drain();
    chk(slvFrames == framesBefore + 3, $sformatf("R10 frames after reset: got %0d exp %0d", slvFrames, framesBefore + 3));
    chk(results == reqCount, $sformatf("R8 result count: got %0d exp %0d", results, reqCount));
    chk(slvFrames == reqCount, $sformatf("R9 frames per request: got %0d exp %0d", slvFrames, reqCount));
    chk(readyInFrame == 0, $sformatf("R9 ready inside frame: got %0d exp 0", readyInFrame));
    chk(expD.size() == 0, $sformatf("R11 pending results: got %0d exp 0", expD.size()));
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vecs++; errs++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule